// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Block

This block is the host-side register set of a simple SCSI bus controller. A processor reaches it through a word-aligned bus of 16-bit registers. The registers hold an interrupt enable, the controller's own bus ID, a target ID, a data byte and a DMA timing mode. Two status registers report the connection state and the data-transfer state. Their bits are a mix of read-only flags, write-1-to-clear flags and plain writable bits.

A command register drives a small sequencer that carries out select, disconnect and programmed-I/O transfer commands. The bus side is reduced to strobes and live fields. Event inputs set status flags, two live fields give the current bus phase, and a detector input supplies the read-only selection status. Two summary bits collect the pending status flags, and they feed one level-sensitive interrupt line.

Reads are combinational from the address. A write takes effect at the clock edge that samples it. The sequencer acts on the stored command one edge later.

Top module: `scsi_regblk`

## Requirements
- R1: The registers sit at byte offsets 0x00 (diagnostic, 16 bits), 0x0C (control), 0x10 (own ID), 0x14 (target ID), 0x18 (detector status), 0x20 (data), 0x24 (DMA mode), 0x48 (connection status), 0x4C (transfer status), 0x50 (command) and 0x54 (diagnostic control, 16 bits). A read of any other address returns 0. A write to any other address changes nothing. An access with address bit 1 or bit 0 set is ignored: a write changes nothing and a read returns 0.
- R2: Register widths are fixed. The own-ID and target registers store only data bits [2:0]. The data register stores only bits [7:0]. The DMA-mode register stores only bits [1:0]. Output `dma_sync` is 1 when the stored DMA mode is nonzero (synchronous) and 0 when it is zero (asynchronous).
- R3: The detector status register always reads the `detect_stat` input. Writes to it have no effect.
- R4: Connection status is written as follows.
  - Writing 1 to bit 13, 12, 11, 9, 8, 7 or 3 clears that bit.
  - Bits in mask 0x3BF7 otherwise keep their value.
  - Bit 3 and every other bit outside the mask take the written value, except for the overlaid bits.
  - Bits [5:4] always read `link_state`.
- R5: Transfer status is written as follows.
  - Writing 1 to bit 13, 11, 10, 4 or 3 clears that bit.
  - Bits in mask 0x0C17 otherwise keep their value.
  - The remaining bits take the written value.
  - Bits [1:0] always read `xfer_phase`.
- R6: The summary bits appear in both status registers.
  - Bit 15 of both registers is the OR of connection flags 13 (bus reset), 12 (bus error), 11 (out of buffer), 9 (buffer), 8 (link done) and 7 (state change).
  - Bit 14 of both registers is the OR of transfer flags 13 (phase mismatch), 11 (input full), 10 (transmit empty) and 4 (done).
  - A 1 on `ev_cstat` or `ev_dstat` sets the matching stored status bits at the next edge.
- R7: `irq` is 1 exactly while control bit 0 (interrupt enable) is 1 and summary bit 15 or summary bit 14 is 1. It responds in the same cycle.
- R8: The disconnect command is command bit 12. It performs three actions:
  - It clears connection-status bit 6 (connected) and bit 2 (selection in progress).
  - It sets bit 7 (state change) only if bit 6 was 1.
  - It clears itself.
- R9: The select command is command bit 11. It sets bit 2, clears bit 6 without setting bit 7, and clears itself. When disconnect and select are both pending, the disconnect is applied first.
- R10: The transfer command is command bit 10, with command bit 9 selecting DMA. It completes only when all of the following hold:
  - Bit 9 is 0.
  - Command bits [6:4] equal connection status bits [6:4].
  - Command bits [1:0] equal transfer status bits [1:0].
  - Selection in progress is 0 after any disconnect or select in the same step.

  On completion, command bit 10 clears and transfer-status bit 10 (transmit empty) sets. Otherwise the command stays pending.
- R11: Command bit 15 (reset request) is forced to 0 on every command write and never reads as 1.
- R12: The sequencer acts on the stored command one clock after the write and on every clock after that. A read in the cycle right after the write returns the command as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, combinational |
| detect_stat | input | DATA_W | Value of the read-only detector status register |
| link_state | input | 2 | Live connection-status bits [5:4] |
| xfer_phase | input | 2 | Live transfer-status bits [1:0] |
| ev_cstat | input | DATA_W | Bus-side set strobes for connection status |
| ev_dstat | input | DATA_W | Bus-side set strobes for transfer status |
| irq | output | 1 | Level interrupt |
| dma_sync | output | 1 | DMA mode is synchronous |

## Verification
Some results are due in the same cycle as the stimulus: read data, `irq` and `dma_sync` follow their sources combinationally. Other results are due one edge later: register writes and event strobes become visible in the cycle after they are driven. Sequencer results are due two edges after the command write. The cycle right after the write still shows the command as written, and the following cycle shows the cleared command bits and the updated status. Each expected item is queued with the cycle number in which it falls due. The monitor compares it at a quarter period after the falling edge of exactly that cycle.

// File: rtl/scsi_regblk_pkg.sv
package scsi_regblk_pkg;

   localparam int NREG = 11;

   // register indices (decode order)
   localparam int RI_DIAG   = 0;
   localparam int RI_CTRL   = 1;
   localparam int RI_OWNID  = 2;
   localparam int RI_TARGET = 3;
   localparam int RI_DETECT = 4;
   localparam int RI_DATA   = 5;
   localparam int RI_DMA    = 6;
   localparam int RI_CSTAT  = 7;
   localparam int RI_DSTAT  = 8;
   localparam int RI_CMD    = 9;
   localparam int RI_DCTL   = 10;

   function automatic logic [7:0] reg_offset(input int idx);
      case (idx)
         RI_DIAG:   return 8'h00;
         RI_CTRL:   return 8'h0C;
         RI_OWNID:  return 8'h10;
         RI_TARGET: return 8'h14;
         RI_DETECT: return 8'h18;
         RI_DATA:   return 8'h20;
         RI_DMA:    return 8'h24;
         RI_CSTAT:  return 8'h48;
         RI_DSTAT:  return 8'h4C;
         RI_CMD:    return 8'h50;
         default:   return 8'h54;
      endcase
   endfunction

   // connection status bit positions
   localparam int CS_CONN  = 6;
   localparam int CS_SIP   = 2;
   localparam int CS_STCHG = 7;
   // transfer status bit positions
   localparam int DS_TBE   = 10;
   // summary bits (both status registers)
   localparam int SUM_C    = 15;
   localparam int SUM_D    = 14;
   // command bit positions
   localparam int CMD_RST  = 15;
   localparam int CMD_DISC = 12;
   localparam int CMD_SEL  = 11;
   localparam int CMD_XFER = 10;
   localparam int CMD_DMA  = 9;

   localparam logic [15:0] CS_KEEP  = 16'h3BF7;
   localparam logic [15:0] CS_W1C   = 16'h3B88;
   localparam logic [15:0] CS_FLAGS = 16'h3B80;
   localparam logic [15:0] CS_OVL   = 16'hC030;
   localparam logic [15:0] DS_KEEP  = 16'h0C17;
   localparam logic [15:0] DS_W1C   = 16'h2C18;
   localparam logic [15:0] DS_FLAGS = 16'h2C10;
   localparam logic [15:0] DS_OVL   = 16'hC003;

endpackage

// File: rtl/scsi_regblk_dec.sv
module scsi_regblk_dec
   import scsi_regblk_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [NREG-1:0]   wr_hit,
   output logic [NREG-1:0]   rd_hit
);
   logic aligned;
   logic [NREG-1:0] match;

   assign aligned = (req_addr[1:0] == 2'b00);

   for (genvar i = 0; i < NREG; i++) begin : g_match
      assign match[i]  = aligned && (req_addr == ADDR_W'(reg_offset(i)));
      assign wr_hit[i] = match[i] && req_valid && req_write;
      assign rd_hit[i] = match[i] && req_valid && !req_write;
   end
endmodule

// File: rtl/scsi_stat_reg.sv
module scsi_stat_reg #(
   parameter int           W    = 16,
   parameter logic [W-1:0] KEEP = '0,
   parameter logic [W-1:0] W1C  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] clr,
   input  logic [W-1:0] set,
   output logic [W-1:0] q
);
   logic [W-1:0] merged;

   always_comb begin
      if (wr)
         merged = (q & KEEP & ~(wdata & W1C)) | (wdata & ~KEEP & ~W1C);
      else
         merged = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (merged & ~clr) | set;
   end
endmodule

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq
   import scsi_regblk_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cstat_rd,
   input  logic [1:0]        xfer_phase_rd,
   output logic [DATA_W-1:0] comm_q,
   output logic [DATA_W-1:0] cs_set,
   output logic [DATA_W-1:0] cs_clr,
   output logic [DATA_W-1:0] ds_set
);
   logic [DATA_W-1:0] c_mid;
   logic [DATA_W-1:0] autoclr;
   logic              xfer_ok;

   always_comb begin
      c_mid   = cstat_rd;
      cs_set  = '0;
      cs_clr  = '0;
      ds_set  = '0;
      autoclr = '0;
      xfer_ok = 1'b0;
      if (comm_q[CMD_DISC]) begin
         cs_clr[CS_CONN] = 1'b1;
         cs_clr[CS_SIP]  = 1'b1;
         if (cstat_rd[CS_CONN]) cs_set[CS_STCHG] = 1'b1;
         c_mid[CS_CONN]    = 1'b0;
         c_mid[CS_SIP]     = 1'b0;
         autoclr[CMD_DISC] = 1'b1;
      end
      if (comm_q[CMD_SEL]) begin
         cs_set[CS_SIP]   = 1'b1;
         cs_clr[CS_CONN]  = 1'b1;
         c_mid[CS_SIP]    = 1'b1;
         c_mid[CS_CONN]   = 1'b0;
         autoclr[CMD_SEL] = 1'b1;
      end
      xfer_ok = comm_q[CMD_XFER] && !comm_q[CMD_DMA]
                && (comm_q[6:4] == c_mid[6:4])
                && (comm_q[1:0] == xfer_phase_rd)
                && !c_mid[CS_SIP];
      if (xfer_ok) begin
         autoclr[CMD_XFER] = 1'b1;
         ds_set[DS_TBE]    = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         comm_q <= '0;
      end else if (wr) begin
         comm_q <= wdata;
         comm_q[CMD_RST] <= 1'b0;
      end else begin
         comm_q <= comm_q & ~autoclr;
      end
   end
endmodule

// File: rtl/scsi_regblk.sv
module scsi_regblk
   import scsi_regblk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int ID_W   = 3,
   parameter int BYTE_W = 8,
   parameter int DMA_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] detect_stat,
   input  logic [1:0]        link_state,
   input  logic [1:0]        xfer_phase,
   input  logic [DATA_W-1:0] ev_cstat,
   input  logic [DATA_W-1:0] ev_dstat,
   output logic              irq,
   output logic              dma_sync
);
   localparam int MIN_ADDR_W = 7;

   if (DATA_W != 16) begin : g_bad_data_w
      $error("scsi_regblk: DATA_W must be 16, status layout is fixed");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("scsi_regblk: ADDR_W too small for offset 0x54");
   end
   if (ID_W < 1 || ID_W > BYTE_W) begin : g_bad_id_w
      $error("scsi_regblk: ID_W out of range");
   end
   if (DMA_W < 1 || DMA_W > 4) begin : g_bad_dma_w
      $error("scsi_regblk: DMA_W out of range");
   end

   logic [NREG-1:0]   wr_hit, rd_hit;
   logic [DATA_W-1:0] diag_q, ctrl_q, dctl_q;
   logic [ID_W-1:0]   own_id_q, target_q;
   logic [BYTE_W-1:0] data_q;
   logic [DMA_W-1:0]  dma_q;
   logic [DATA_W-1:0] cs_q, ds_q, cstat_rd, dstat_rd, comm_q;
   logic [DATA_W-1:0] seq_cs_set, seq_cs_clr, seq_ds_set;
   logic [DATA_W-1:0] cs_ovl, ds_ovl;
   logic              sum_c, sum_d;
   logic [DATA_W-1:0] rd_val [NREG];

   scsi_regblk_dec #(.ADDR_W(ADDR_W)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .wr_hit    (wr_hit),
      .rd_hit    (rd_hit)
   );

   // plain configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diag_q   <= '0;
         ctrl_q   <= '0;
         dctl_q   <= '0;
         own_id_q <= '0;
         target_q <= '0;
         data_q   <= '0;
         dma_q    <= '0;
      end else begin
         if (wr_hit[RI_DIAG])   diag_q   <= req_wdata;
         if (wr_hit[RI_CTRL])   ctrl_q   <= req_wdata;
         if (wr_hit[RI_DCTL])   dctl_q   <= req_wdata;
         if (wr_hit[RI_OWNID])  own_id_q <= req_wdata[ID_W-1:0];
         if (wr_hit[RI_TARGET]) target_q <= req_wdata[ID_W-1:0];
         if (wr_hit[RI_DATA])   data_q   <= req_wdata[BYTE_W-1:0];
         if (wr_hit[RI_DMA])    dma_q    <= req_wdata[DMA_W-1:0];
      end
   end

   scsi_stat_reg #(.W(DATA_W), .KEEP(CS_KEEP), .W1C(CS_W1C)) u_cstat (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_hit[RI_CSTAT]),
      .wdata (req_wdata),
      .clr   (seq_cs_clr),
      .set   (seq_cs_set | ev_cstat),
      .q     (cs_q)
   );

   scsi_stat_reg #(.W(DATA_W), .KEEP(DS_KEEP), .W1C(DS_W1C)) u_dstat (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_hit[RI_DSTAT]),
      .wdata (req_wdata),
      .clr   ('0),
      .set   (seq_ds_set | ev_dstat),
      .q     (ds_q)
   );

   // summary bits and live overlays
   assign sum_c = |(cs_q & CS_FLAGS);
   assign sum_d = |(ds_q & DS_FLAGS);

   always_comb begin
      cs_ovl = '0;
      cs_ovl[SUM_C] = sum_c;
      cs_ovl[SUM_D] = sum_d;
      cs_ovl[5:4]   = link_state;
      ds_ovl = '0;
      ds_ovl[SUM_C] = sum_c;
      ds_ovl[SUM_D] = sum_d;
      ds_ovl[1:0]   = xfer_phase;
   end

   assign cstat_rd = (cs_q & ~CS_OVL) | cs_ovl;
   assign dstat_rd = (ds_q & ~DS_OVL) | ds_ovl;

   scsi_cmd_seq #(.DATA_W(DATA_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr            (wr_hit[RI_CMD]),
      .wdata         (req_wdata),
      .cstat_rd      (cstat_rd),
      .xfer_phase_rd (xfer_phase),
      .comm_q        (comm_q),
      .cs_set        (seq_cs_set),
      .cs_clr        (seq_cs_clr),
      .ds_set        (seq_ds_set)
   );

   assign irq      = ctrl_q[0] && (sum_c || sum_d);
   assign dma_sync = |dma_q;

   // read mux
   always_comb begin
      rd_val[RI_DIAG]   = diag_q;
      rd_val[RI_CTRL]   = ctrl_q;
      rd_val[RI_OWNID]  = DATA_W'(own_id_q);
      rd_val[RI_TARGET] = DATA_W'(target_q);
      rd_val[RI_DETECT] = detect_stat;
      rd_val[RI_DATA]   = DATA_W'(data_q);
      rd_val[RI_DMA]    = DATA_W'(dma_q);
      rd_val[RI_CSTAT]  = cstat_rd;
      rd_val[RI_DSTAT]  = dstat_rd;
      rd_val[RI_CMD]    = comm_q;
      rd_val[RI_DCTL]   = dctl_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (rd_hit[i]) rd_data = rd_val[i];
   end
endmodule

// File: rtl/scsi_regblk_chk.sv
module scsi_regblk_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int ID_W   = 3,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] ev_cstat,
   input logic              irq,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [ID_W-1:0]   own_id_q,
   input logic [BYTE_W-1:0] data_q,
   input logic [DATA_W-1:0] comm_q,
   input logic [DATA_W-1:0] cstat_rd,
   input logic [DATA_W-1:0] dstat_rd
);
   logic wr_cmd, wr_misal;
   assign wr_cmd   = req_valid && req_write && (req_addr == ADDR_W'(8'h50));
   assign wr_misal = req_valid && req_write && (req_addr[1:0] != 2'b00);

   p_misaligned_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_misal |=> ($stable(ctrl_q) && $stable(own_id_q) && $stable(data_q)));

   p_flag_sets_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dstat_rd[13] || dstat_rd[11]) |-> (cstat_rd[14] && dstat_rd[14]));

   p_irq_when_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && (cstat_rd[15] || dstat_rd[14])) |-> irq);

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[0] |-> !irq);

   p_disc_state_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (comm_q[12] && cstat_rd[6] && !wr_cmd) |=> (cstat_rd[7] && !comm_q[12]));

   p_select_sets_sip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (comm_q[11] && !wr_cmd && !ev_cstat[6]) |=>
         (cstat_rd[2] && !cstat_rd[6] && !comm_q[11]));

   p_xfer_done_tbe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(comm_q[10]) && !comm_q[10] && !$past(wr_cmd)) |-> dstat_rd[10]);

   p_dma_xfer_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (comm_q[10] && comm_q[9] && !wr_cmd) |=> comm_q[10]);

   p_rst_bit_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !comm_q[15]);
endmodule

bind scsi_regblk scsi_regblk_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .BYTE_W(BYTE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .ev_cstat  (ev_cstat),
   .irq       (irq),
   .ctrl_q    (ctrl_q),
   .own_id_q  (own_id_q),
   .data_q    (data_q),
   .comm_q    (comm_q),
   .cstat_rd  (cstat_rd),
   .dstat_rd  (dstat_rd)
);

// File: tb/scsi_regblk_tb_top.sv
module scsi_regblk_tb_top;
   localparam int CLK_P   = 10;
   localparam int WDOG    = 200000;
   localparam int K_RD    = 0;
   localparam int K_IRQ   = 1;
   localparam int K_SYNC  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [15:0] req_wdata = '0, rd_data;
   logic [15:0] detect_stat = '0, ev_cstat = '0, ev_dstat = '0;
   logic [1:0]  link_state = '0, xfer_phase = '0;
   logic        irq, dma_sync;

   int cyc_cnt = 0;
   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      int          cyc;
      int          kind;
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   scsi_regblk dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
      .detect_stat(detect_stat), .link_state(link_state), .xfer_phase(xfer_phase),
      .ev_cstat(ev_cstat), .ev_dstat(ev_dstat),
      .irq(irq), .dma_sync(dma_sync)
   );

   // driver tasks
   task automatic step();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      ev_cstat  = '0;   ev_dstat  = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      step();
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
   endtask

   task automatic expect_item(input int k, input logic [15:0] e, input string t);
      item_t it;
      it.cyc = cyc_cnt; it.kind = k; it.exp = e; it.tag = t;
      sb.push_back(it);
   endtask

   task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
      step();
      req_valid = 1'b1; req_addr = a;
      expect_item(K_RD, e, t);
   endtask

   task automatic pin(input int k, input logic e, input string t);
      step();
      expect_item(k, {15'd0, e}, t);
   endtask

   task automatic pulse(input logic [15:0] c, input logic [15:0] d);
      step();
      ev_cstat = c; ev_dstat = d;
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (sb.size() > 0 && sb[0].cyc == cyc_cnt) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.kind)
               K_RD:    act = rd_data;
               K_IRQ:   act = {15'd0, irq};
               default: act = {15'd0, dma_sync};
            endcase
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      rd(8'h0C, 16'h0000, "R1 ctrl reset");
      rd(8'h48, 16'h0000, "R6 cstat reset");
      rd(8'h4C, 16'h0000, "R6 dstat reset");
      rd(8'h50, 16'h0000, "R11 cmd reset");
      pin(K_IRQ, 1'b0, "R7 irq reset");
      // R2 widths
      wr(8'h10, 16'h00FF); rd(8'h10, 16'h0007, "R2 own id");
      wr(8'h14, 16'hABCD); rd(8'h14, 16'h0005, "R2 target");
      wr(8'h20, 16'h1234); rd(8'h20, 16'h0034, "R2 data");
      wr(8'h24, 16'hFFFE); rd(8'h24, 16'h0002, "R2 dma mode");
      pin(K_SYNC, 1'b1, "R2 dma sync");
      wr(8'h24, 16'h0000); pin(K_SYNC, 1'b0, "R2 dma async");
      // R3 detector read-only
      step(); detect_stat = 16'h005A;
      wr(8'h18, 16'hFFFF); rd(8'h18, 16'h005A, "R3 detect read-only");
      // R1 map and misaligned
      wr(8'h11, 16'h0000); wr(8'h12, 16'h0000);
      rd(8'h10, 16'h0007, "R1 misaligned write ignored");
      wr(8'h00, 16'hBEEF); rd(8'h00, 16'hBEEF, "R1 diag");
      wr(8'h54, 16'h1234); rd(8'h54, 16'h1234, "R1 diag ctrl");
      rd(8'h0E, 16'h0000, "R1 misaligned read");
      wr(8'h30, 16'hFFFF); rd(8'h30, 16'h0000, "R1 unmapped");
      // R4/R6 connection status
      pulse(16'h3FFF, 16'h0000);
      rd(8'h48, 16'hBFCF, "R6 cstat events and summary");
      rd(8'h4C, 16'h8000, "R6 summary mirrored");
      wr(8'h48, 16'h0000); rd(8'h48, 16'hBBC7, "R4 keep mask");
      wr(8'h48, 16'h3400); rd(8'h48, 16'h8FC7, "R4 w1c and direct");
      wr(8'h48, 16'h0B80); rd(8'h48, 16'h0047, "R4 w1c flags");
      // R5 transfer status
      pulse(16'h0000, 16'h3FFC);
      rd(8'h4C, 16'h7FFC, "R5 dstat events");
      rd(8'h48, 16'h4047, "R6 di mirrored");
      wr(8'h4C, 16'h0000); rd(8'h4C, 16'h4C14, "R5 keep mask");
      wr(8'h4C, 16'h0E10); rd(8'h4C, 16'h0204, "R5 w1c and direct");
      // R7 interrupt
      wr(8'h0C, 16'h0001); pin(K_IRQ, 1'b0, "R7 nothing pending");
      pulse(16'h0000, 16'h0800);
      rd(8'h4C, 16'h4A04, "R6 input full");
      pin(K_IRQ, 1'b1, "R7 irq asserted");
      wr(8'h0C, 16'h0000); pin(K_IRQ, 1'b0, "R7 irq masked");
      wr(8'h0C, 16'h0001); pin(K_IRQ, 1'b1, "R7 irq unmasked");
      wr(8'h4C, 16'h0800); pin(K_IRQ, 1'b0, "R7 irq cleared");
      rd(8'h4C, 16'h0004, "R5 flag cleared");
      // R8 disconnect while connected, R12 timing
      wr(8'h50, 16'h1000);
      rd(8'h50, 16'h1000, "R12 cmd visible before action");
      rd(8'h50, 16'h0000, "R8 disconnect self-clears");
      rd(8'h48, 16'h8083, "R8 state change");
      pin(K_IRQ, 1'b1, "R7 irq on state change");
      wr(8'h48, 16'h0080); rd(8'h48, 16'h0003, "R4 clear state change");
      wr(8'h50, 16'h1000); step();
      rd(8'h48, 16'h0003, "R8 no change when idle");
      // R9 select
      wr(8'h50, 16'h0800); step();
      rd(8'h48, 16'h0007, "R9 select sets sip");
      pulse(16'h0040, 16'h0000);
      rd(8'h48, 16'h0047, "R6 connect event");
      wr(8'h50, 16'h0800); step();
      rd(8'h48, 16'h0007, "R9 select drops connection");
      rd(8'h50, 16'h0000, "R9 select self-clears");
      // R10 transfer
      step(); link_state = 2'b10; xfer_phase = 2'b01;
      wr(8'h50, 16'h0421); step();
      rd(8'h50, 16'h0421, "R10 blocked by sip");
      rd(8'h4C, 16'h0005, "R10 no tbe while blocked");
      wr(8'h50, 16'h1421); step();
      rd(8'h50, 16'h0021, "R10 disconnect then transfer");
      rd(8'h4C, 16'h4405, "R10 tbe set");
      rd(8'h48, 16'h4023, "R6 live link field and di");
      wr(8'h4C, 16'h0400); rd(8'h4C, 16'h0005, "R5 tbe cleared");
      wr(8'h50, 16'h0422); step();
      rd(8'h50, 16'h0422, "R10 phase mismatch holds");
      wr(8'h50, 16'h0621); step();
      rd(8'h50, 16'h0621, "R10 dma mode holds");
      rd(8'h4C, 16'h0005, "R10 no tbe in dma");
      wr(8'h50, 16'h0421);
      rd(8'h50, 16'h0421, "R12 transfer pending one cycle");
      rd(8'h50, 16'h0021, "R10 transfer completes");
      rd(8'h4C, 16'h4405, "R10 tbe after pio");
      // R11 reset request bit
      wr(8'h50, 16'h8000); rd(8'h50, 16'h0000, "R11 reset bit dropped");
      wr(8'h50, 16'h8021); rd(8'h50, 16'h0021, "R11 rest kept");
      step(); step(); step();
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule